// File: doc/BRIEF.md
# I2C Target Controller with Clock Stretching

This block is the target (slave) side of a two-wire I2C bus, placed between the bus pins and a host register interface. It synchronises the SCL and SDA inputs, detects START, repeated START and STOP, and shifts in the address byte. A programmable 7-bit address decides whether the target takes part in the transfer. Acceptance can be widened to the general-call address or, in promiscuous mode, to every address.

After each event that needs software, the block holds SCL low and raises a flag:
- an accepted address raises the address/stop flag;
- a received data byte, or a request for a transmit byte, raises the data flag.

SCL stays low until the host issues a command. The command either continues the transfer or ends it. Continuing means sending ACK or NACK chosen by a single bit, or loading the next byte to transmit. Ending returns the target to idle. A START followed at once by a STOP raises a bus-error flag.

The pins are open-drain and are modelled as drive-low enables. The board or bench resolves the bus as a wired AND.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset neither line is driven low, all three flags are 0, and the target ignores bus activity until a START (SDA falling while SCL is high).
- R2: An address byte whose upper seven bits equal `own_addr_i` is accepted. The address/stop flag rises, SCL is held low, `rx_data_o` holds the whole address byte, and `dir_o` shows its bit 0 (1 = master read).
- R3: A non-matching address is not acknowledged (SDA stays released in the ninth clock). No flag rises, SCL is not stretched and `rx_data_o` keeps its value.
- R4: The general-call address byte 0x00 is accepted like a match while `gcall_en_i` is 1, and rejected while it is 0.
- R5: With `promisc_en_i` = 1, every address byte is accepted.
- R6: A STOP that arrives after a START with no SCL rising edge between them sets `bus_err_flag_o`. A STOP that ends a normal transfer does not.
- R7: While stretching, SCL stays low until a command with `cmd_i` = 2'b11 (continue) or 2'b10 (finish) arrives with `cmd_valid_i`. Both codes release SCL. Codes 2'b00 and 2'b01 have no effect.
- R8: Continue after an address or a received byte drives the acknowledge slot from `ackact_i`: 0 pulls SDA low (ACK), 1 leaves it high (NACK). After a NACK the target returns to idle.
- R9: In a master write, each byte received after an ACK sets the data flag, is placed in `rx_data_o`, and SCL is stretched.
- R10: In a master read, an ACKed address sets the data flag. Continue then loads `tx_data_i`, which is shifted out MSB first. A master ACK requests the next byte the same way. A master NACK returns the target to idle with both lines released.
- R11: STOP releases both lines and returns to idle. If `stop_irq_en_i` is 1 and the target was addressed, it also sets the address/stop flag.
- R12: A continue or finish command clears all three flags.
- R13: After a finish command the target ignores further bytes until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_drive_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low_o | output | 1 | Pull SDA low (ACK or data 0) |
| own_addr_i | input | 7 | Programmed target address |
| promisc_en_i | input | 1 | Accept every address |
| gcall_en_i | input | 1 | Accept general call 0x00 |
| stop_irq_en_i | input | 1 | STOP sets address/stop flag when addressed |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_i | input | 2 | 2'b11 continue, 2'b10 finish |
| ackact_i | input | 1 | Acknowledge choice: 0 ACK, 1 NACK |
| tx_data_i | input | 8 | Byte loaded by continue in a master read |
| addr_stop_flag_o | output | 1 | Address accepted or STOP seen |
| data_flag_o | output | 1 | Byte received or transmit byte needed |
| bus_err_flag_o | output | 1 | START directly followed by STOP |
| dir_o | output | 1 | Received R/W bit, 1 = master read |
| rx_data_o | output | 8 | Last accepted address or received byte |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 instead of the default 2, so every bus event reaches the state machine one cycle later. This shows that the stretch and drive timing hold with a deeper synchroniser, because the bench master samples the lines relative to the edges of the resolved bus. The master model honours clock stretching, which makes every software command land inside a held SCL-low phase. Write, read, rejected, general-call, promiscuous and error sequences all take place on one bus.

// File: rtl/i2c_sl_pkg.sv
package i2c_sl_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [1:0] CMD_FINISH   = 2'b10;
    localparam logic [1:0] CMD_CONTINUE = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_MACK
    } sl_state_e;

    typedef struct packed {
        sl_state_e           st;
        logic [BYTE_W-1:0]   shreg;
        logic [CNT_W-1:0]    bitcnt;
        logic [BYTE_W-1:0]   data;
        logic                rd;
        logic                f_addr;
        logic                f_data;
        logic                f_berr;
        logic                sda_low;
        logic                scl_low;
        logic                addressed;
        logic                nack;
        logic                hold_tx;
    } sl_regs_t;

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_sync_q;
    logic [SYNC_STAGES-1:0] sda_sync_q;
    logic                   scl_prev_q;
    logic                   sda_prev_q;
    logic                   scl_now;
    logic                   sda_now;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync_q[g] <= 1'b1;
                    sda_sync_q[g] <= 1'b1;
                end else begin
                    scl_sync_q[g] <= scl_i;
                    sda_sync_q[g] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync_q[g] <= 1'b1;
                    sda_sync_q[g] <= 1'b1;
                end else begin
                    scl_sync_q[g] <= scl_sync_q[g-1];
                    sda_sync_q[g] <= sda_sync_q[g-1];
                end
            end
        end
    end

    assign scl_now = scl_sync_q[SYNC_STAGES-1];
    assign sda_now = sda_sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_now;
            sda_prev_q <= sda_now;
        end
    end

    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_prev_q;
    assign scl_fall_o = ~scl_now & scl_prev_q;
    assign start_o    = scl_now & scl_prev_q & sda_prev_q & ~sda_now;
    assign stop_o     = scl_now & scl_prev_q & ~sda_prev_q & sda_now;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_sl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr7_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              promisc_en_i,
    input  logic              gcall_en_i,
    output logic              hit_o
);

    logic own_hit;
    logic gcall_hit;

    assign own_hit   = (addr7_i == own_addr_i);
    assign gcall_hit = gcall_en_i & (addr7_i == '0);
    assign hit_o     = promisc_en_i | own_hit | gcall_hit;

endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
    import i2c_sl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low_o,
    output logic              sda_drive_low_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              promisc_en_i,
    input  logic              gcall_en_i,
    input  logic              stop_irq_en_i,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_i,
    input  logic              ackact_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              addr_stop_flag_o,
    output logic              data_flag_o,
    output logic              bus_err_flag_o,
    output logic              dir_o,
    output logic [BYTE_W-1:0] rx_data_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    logic bus_sda, bus_rise, bus_fall, bus_start, bus_stop;
    logic addr_hit;
    logic cmd_known;
    sl_regs_t st_d, st_q;

    i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (bus_sda),
        .scl_rise_o (bus_rise),
        .scl_fall_o (bus_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    i2c_addr_match u_match (
        .addr7_i      (st_q.shreg[BYTE_W-1:1]),
        .own_addr_i   (own_addr_i),
        .promisc_en_i (promisc_en_i),
        .gcall_en_i   (gcall_en_i),
        .hit_o        (addr_hit)
    );

    assign cmd_known = cmd_valid_i & cmd_i[1];

    always_comb begin
        st_d = st_q;
        if (cmd_known) begin
            st_d.f_addr = 1'b0;
            st_d.f_data = 1'b0;
            st_d.f_berr = 1'b0;
        end
        if (bus_start) begin
            st_d.st      = ST_ADDR;
            st_d.bitcnt  = '0;
            st_d.sda_low = 1'b0;
            st_d.scl_low = 1'b0;
        end else if (bus_stop) begin
            if (st_q.st == ST_ADDR && st_q.bitcnt == '0) st_d.f_berr = 1'b1;
            if (st_q.addressed && stop_irq_en_i)         st_d.f_addr = 1'b1;
            st_d.st        = ST_IDLE;
            st_d.addressed = 1'b0;
            st_d.sda_low   = 1'b0;
            st_d.scl_low   = 1'b0;
        end else begin
            case (st_q.st)
                ST_ADDR, ST_RX: begin
                    if (bus_rise) begin
                        st_d.shreg  = {st_q.shreg[BYTE_W-2:0], bus_sda};
                        st_d.bitcnt = st_q.bitcnt + 1'b1;
                    end else if (bus_fall && st_q.bitcnt == FULL_CNT) begin
                        if (st_q.st == ST_ADDR && !addr_hit) begin
                            st_d.st        = ST_IDLE;
                            st_d.addressed = 1'b0;
                        end else begin
                            st_d.data    = st_q.shreg;
                            st_d.hold_tx = 1'b0;
                            st_d.scl_low = 1'b1;
                            st_d.st      = ST_HOLD;
                            if (st_q.st == ST_ADDR) begin
                                st_d.rd        = st_q.shreg[0];
                                st_d.f_addr    = 1'b1;
                                st_d.addressed = 1'b1;
                            end else begin
                                st_d.f_data = 1'b1;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (cmd_known) begin
                        st_d.scl_low = 1'b0;
                        if (cmd_i == CMD_FINISH) begin
                            st_d.st = ST_IDLE;
                        end else if (st_q.hold_tx) begin
                            st_d.shreg   = tx_data_i;
                            st_d.sda_low = ~tx_data_i[BYTE_W-1];
                            st_d.bitcnt  = '0;
                            st_d.st      = ST_TX;
                        end else begin
                            st_d.sda_low = ~ackact_i;
                            st_d.nack    = ackact_i;
                            st_d.st      = ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (bus_fall) begin
                        st_d.sda_low = 1'b0;
                        if (st_q.nack) begin
                            st_d.st = ST_IDLE;
                        end else if (st_q.rd) begin
                            st_d.hold_tx = 1'b1;
                            st_d.f_data  = 1'b1;
                            st_d.scl_low = 1'b1;
                            st_d.st      = ST_HOLD;
                        end else begin
                            st_d.bitcnt = '0;
                            st_d.st     = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (bus_fall) begin
                        if (st_q.bitcnt == LAST_TX) begin
                            st_d.sda_low = 1'b0;
                            st_d.st      = ST_MACK;
                        end else begin
                            st_d.sda_low = ~st_q.shreg[BYTE_W-2];
                            st_d.shreg   = {st_q.shreg[BYTE_W-2:0], 1'b0};
                            st_d.bitcnt  = st_q.bitcnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (bus_rise) begin
                        st_d.nack = bus_sda;
                    end else if (bus_fall) begin
                        if (st_q.nack) begin
                            st_d.st = ST_IDLE;
                        end else begin
                            st_d.hold_tx = 1'b1;
                            st_d.f_data  = 1'b1;
                            st_d.scl_low = 1'b1;
                            st_d.st      = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_drive_low_o  = st_q.scl_low;
    assign sda_drive_low_o  = st_q.sda_low;
    assign addr_stop_flag_o = st_q.f_addr;
    assign data_flag_o      = st_q.f_data;
    assign bus_err_flag_o   = st_q.f_berr;
    assign dir_o            = st_q.rd;
    assign rx_data_o        = st_q.data;

endmodule

// File: rtl/i2c_stretch_slave_chk.sv
module i2c_stretch_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_i,
    input logic       cmd_valid_i,
    input logic [1:0] cmd_i,
    input logic       scl_low_i,
    input logic       sda_low_i,
    input logic       f_addr_i,
    input logic       f_data_i,
    input logic       f_berr_i
);

    AST_STRETCH_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        scl_low_i |-> (f_addr_i || f_data_i)); // R7

    AST_CMD_RELEASES_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_i[1] && scl_low_i) |=> !scl_low_i); // R7

    AST_BERR_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_berr_i) |-> $past(stop_i)); // R6

    AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!scl_low_i && !sda_low_i)); // R11

    AST_ACCEPT_STRETCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(f_addr_i) && !$past(stop_i)) |-> scl_low_i); // R2

    AST_CMD_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_i[1] && !stop_i) |=> (!f_berr_i)); // R12

endmodule

bind i2c_stretch_slave i2c_stretch_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (bus_stop),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .scl_low_i   (scl_drive_low_o),
    .sda_low_i   (sda_drive_low_o),
    .f_addr_i    (addr_stop_flag_o),
    .f_data_i    (data_flag_o),
    .f_berr_i    (bus_err_flag_o)
);

// File: tb/i2c_stretch_slave_tb.sv
module i2c_stretch_slave_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       scl_bus, sda_bus;
    logic       scl_dl, sda_dl;
    logic [6:0] own_addr = 7'h2C;
    logic       promisc = 1'b0;
    logic       gcall = 1'b1;
    logic       stop_irq = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic       ackact = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       f_addr, f_data, f_berr, dir;
    logic [7:0] rx_data;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;

    assign scl_bus = m_scl & ~scl_dl;
    assign sda_bus = m_sda & ~sda_dl;

    i2c_stretch_slave #(.SYNC_STAGES(3)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .scl_i            (scl_bus),
        .sda_i            (sda_bus),
        .scl_drive_low_o  (scl_dl),
        .sda_drive_low_o  (sda_dl),
        .own_addr_i       (own_addr),
        .promisc_en_i     (promisc),
        .gcall_en_i       (gcall),
        .stop_irq_en_i    (stop_irq),
        .cmd_valid_i      (cmd_valid),
        .cmd_i            (cmd),
        .ackact_i         (ackact),
        .tx_data_i        (tx_data),
        .addr_stop_flag_o (f_addr),
        .data_flag_o      (f_data),
        .bus_err_flag_o   (f_berr),
        .dir_o            (dir),
        .rx_data_o        (rx_data)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic hq();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hq();
        m_scl = 1'b1; hq();
        m_sda = 1'b0; hq();
        m_scl = 1'b0; hq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hq();
        m_scl = 1'b1; hq();
        m_sda = 1'b1; hq();
    endtask

    task automatic wbit(input logic b);
        m_sda = b; hq();
        m_scl = 1'b1;
        wait (scl_bus === 1'b1);
        @(negedge clk);
        hq();
        m_scl = 1'b0; hq();
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; hq();
        m_scl = 1'b1;
        wait (scl_bus === 1'b1);
        @(negedge clk);
        hq();
        b = sda_bus;
        m_scl = 1'b0; hq();
    endtask

    task automatic wbyte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) wbit(v[i]);
    endtask

    task automatic rbyte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
    endtask

    task automatic sw_cmd(input logic [1:0] c, input logic ak, input logic [7:0] tx);
        @(negedge clk);
        cmd = c; ackact = ak; tx_data = tx; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 scl released", scl_dl, 0);
        chk("R1 sda released", sda_dl, 0);
        chk("R1 flags clear", {f_addr, f_data, f_berr}, 0);
    endtask

    task automatic t_write();
        logic a;
        bus_start();
        wbyte({7'h2C, 1'b0});
        chk("R2 stretch", scl_dl, 1);
        chk("R2 addr flag", f_addr, 1);
        chk("R2 rx addr", rx_data, 8'h58);
        chk("R2 dir write", dir, 0);
        sw_cmd(2'b01, 1'b0, 8'h00);
        chk("R7 code 01 ignored stretch", scl_dl, 1);
        chk("R7 code 01 ignored flag", f_addr, 1);
        sw_cmd(2'b11, 1'b0, 8'h00);
        chk("R7 released", scl_dl, 0);
        chk("R12 addr flag cleared", f_addr, 0);
        rbit(a);
        chk("R8 ack low", a, 0);
        wbyte(8'h3C);
        chk("R9 data flag", f_data, 1);
        chk("R9 rx byte", rx_data, 8'h3C);
        chk("R9 stretch", scl_dl, 1);
        sw_cmd(2'b11, 1'b1, 8'h00);
        rbit(a);
        chk("R8 nack high", a, 1);
        chk("R8 idle after nack", {scl_dl, sda_dl}, 0);
        bus_stop();
        chk("R11 no stop flag when disabled", f_addr, 0);
        chk("R6 no berr on normal stop", f_berr, 0);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] v;
        bus_start();
        wbyte({7'h2C, 1'b1});
        chk("R2 dir read", dir, 1);
        sw_cmd(2'b11, 1'b0, 8'h00);
        rbit(a);
        chk("R10 address ack", a, 0);
        chk("R10 data request", f_data, 1);
        chk("R10 stretch", scl_dl, 1);
        sw_cmd(2'b11, 1'b0, 8'hA5);
        rbyte(v);
        chk("R10 first tx byte", v, 8'hA5);
        wbit(1'b0);
        chk("R10 next request", {f_data, scl_dl}, 2'b11);
        sw_cmd(2'b11, 1'b0, 8'h3C);
        rbyte(v);
        chk("R10 second tx byte", v, 8'h3C);
        wbit(1'b1);
        chk("R10 idle after master nack", {scl_dl, sda_dl, f_data}, 0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        wbyte({7'h2D, 1'b0});
        chk("R3 no stretch", scl_dl, 0);
        chk("R3 no flag", f_addr, 0);
        rbit(a);
        chk("R3 no ack", a, 1);
        chk("R3 rx unchanged", rx_data, 8'h59);
        bus_stop();
    endtask

    task automatic t_gcall();
        logic a;
        bus_start();
        wbyte(8'h00);
        chk("R4 gcall accepted", {f_addr, scl_dl}, 2'b11);
        chk("R4 rx zero", rx_data, 8'h00);
        sw_cmd(2'b10, 1'b0, 8'h00);
        chk("R13 finish releases", {scl_dl, f_addr}, 0);
        rbit(a);
        chk("R13 no ack after finish", a, 1);
        wbyte(8'h55);
        chk("R13 byte ignored", {scl_dl, f_data}, 0);
        chk("R13 rx kept", rx_data, 8'h00);
        bus_stop();
        gcall = 1'b0;
        bus_start();
        wbyte(8'h00);
        chk("R4 gcall rejected", {f_addr, scl_dl}, 0);
        rbit(a);
        bus_stop();
        gcall = 1'b1;
    endtask

    task automatic t_promisc();
        logic a;
        promisc = 1'b1;
        bus_start();
        wbyte(8'hE4);
        chk("R5 any address accepted", {f_addr, scl_dl}, 2'b11);
        chk("R5 rx addr", rx_data, 8'hE4);
        sw_cmd(2'b10, 1'b0, 8'h00);
        rbit(a);
        bus_stop();
        promisc = 1'b0;
    endtask

    task automatic t_berr();
        m_sda = 1'b1; m_scl = 1'b1; hq();
        m_sda = 1'b0; hq();
        m_sda = 1'b1; hq();
        chk("R6 bus error", f_berr, 1);
        sw_cmd(2'b10, 1'b0, 8'h00);
        chk("R12 berr cleared", f_berr, 0);
    endtask

    task automatic t_stopirq();
        logic a;
        stop_irq = 1'b1;
        bus_start();
        wbyte({7'h2C, 1'b0});
        sw_cmd(2'b11, 1'b0, 8'h00);
        rbit(a);
        bus_stop();
        chk("R11 stop flag", f_addr, 1);
        chk("R11 lines free", {scl_dl, sda_dl}, 0);
        sw_cmd(2'b10, 1'b0, 8'h00);
        chk("R12 stop flag cleared", f_addr, 0);
        stop_irq = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_mismatch();
        t_gcall();
        t_promisc();
        t_berr();
        t_stopirq();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule